// File: doc/BRIEF.md
# In-Order Dual-Issue Scoreboard Controller

This block decides, cycle by cycle, which of the two oldest pending instructions of an in-order stream may start on one of two functional units: a single non-pipelined adder and a single non-pipelined multiplier. Each instruction is described by a class bit, a destination register index and two source register indices. A busy bit per architectural register records results that are still in flight. An instruction is held while any register it names is busy, or while the unit it needs is occupied.

The upstream queue presents its oldest entry on slot 0 and the next entry on slot 1. Each cycle it removes whatever the block reports as issued. At most one adder operation and one multiplier operation can start together. Slot 1 never overtakes slot 0. Completion is modelled as a writeback pulse that carries the destination index. The pulse is raised a fixed number of cycles after issue, and the busy bit is dropped at the end of that cycle.

Top module: `sb_dual_issue`

## Requirements
- R1: Reset (synchronous, active low) clears every busy bit and frees both units. A writeback pending at reset is never reported, and its register can be used in the first cycle after reset.
- R2: Slot 1 issues only in a cycle in which slot 0 also issues. An invalid or blocked slot 0 blocks slot 1.
- R3: When the two oldest instructions use different units and slot 1 neither reads nor writes slot 0's destination, both issue in the same cycle. Slot 1 writing a register that slot 0 reads does not prevent this.
- R4: When both slots use the same unit class, only slot 0 can issue in that cycle.
- R5: When slot 1 reads or writes slot 0's destination register, only slot 0 can issue in that cycle.
- R6: An instruction with a source register whose busy bit is set does not issue.
- R7: An instruction whose destination register is busy does not issue, even when its unit is free.
- R8: The adder raises its writeback pulse, with the destination index, exactly 2 cycles after its issue cycle. It accepts a new operation in that writeback cycle and not earlier.
- R9: The multiplier raises its writeback pulse, with the destination index, exactly 5 cycles after its issue cycle. It accepts a new operation in that writeback cycle and not earlier.
- R10: A busy bit is cleared at the end of its writeback cycle. An instruction that was waiting only on that register issues in the following cycle.
- R11: The class input bit and the unit-select outputs share one encoding: 0 selects the adder and 1 selects the multiplier. The unit-select output of an issued slot equals that slot's class bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| s0_vld | input | 1 | Oldest pending instruction present |
| s0_mul | input | 1 | Oldest instruction class (0 adder, 1 multiplier) |
| s0_dst | input | REG_W | Oldest instruction destination register |
| s0_sa | input | REG_W | Oldest instruction first source register |
| s0_sb | input | REG_W | Oldest instruction second source register |
| s1_vld | input | 1 | Second-oldest pending instruction present |
| s1_mul | input | 1 | Second-oldest instruction class |
| s1_dst | input | REG_W | Second-oldest destination register |
| s1_sa | input | REG_W | Second-oldest first source register |
| s1_sb | input | REG_W | Second-oldest second source register |
| iss0_vld | output | 1 | Slot 0 issues this cycle |
| iss0_unit | output | 1 | Unit taken by slot 0 |
| iss1_vld | output | 1 | Slot 1 issues this cycle |
| iss1_unit | output | 1 | Unit taken by slot 1 |
| wb_add_vld | output | 1 | Adder writeback event |
| wb_add_reg | output | REG_W | Register written back by the adder |
| wb_mul_vld | output | 1 | Multiplier writeback event |
| wb_mul_reg | output | REG_W | Register written back by the multiplier |

## Verification
The issue decisions are combinational in the cycle the slots are presented. They are checked a short delay after the inputs change, in the same cycle, before the next rising edge. The adder writeback is checked two cycles after its issue cycle and the multiplier writeback five cycles after. The bench steps one cycle at a time and checks that the pulse is absent in every cycle before that point and present at it. Busy-release checks sample the cycle after the writeback pulse. This is the first cycle in which a waiting instruction may start.

// File: rtl/sb_pkg.sv
// Shared definitions for the dual-issue scoreboard.
// Assumes: the register index width is set once here and all modules
// derive their register counts from it.
package sb_pkg;
    localparam int SB_REG_W   = 4;
    localparam int SB_LAT_ADD = 2;
    localparam int SB_LAT_MUL = 5;

    // class / unit-select encoding, shared by inputs and outputs
    localparam logic UNIT_ADD = 1'b0;
    localparam logic UNIT_MUL = 1'b1;
endpackage

// File: rtl/sb_busy_table.sv
// Per-register in-flight table.
// What: one busy bit per register, set by up to two issues and cleared
// by up to two writeback events in the same cycle.
// Assumes: a register being set is never being cleared in the same
// cycle (the issue check refuses a busy destination); set wins anyway.
module sb_busy_table #(
    parameter int REG_W = sb_pkg::SB_REG_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  set_a_en,
    input  logic [REG_W-1:0]      set_a_idx,
    input  logic                  set_b_en,
    input  logic [REG_W-1:0]      set_b_idx,
    input  logic                  clr_a_en,
    input  logic [REG_W-1:0]      clr_a_idx,
    input  logic                  clr_b_en,
    input  logic [REG_W-1:0]      clr_b_idx,
    output logic [(1<<REG_W)-1:0] busy
);
    localparam int NREG = 1 << REG_W;

    for (genvar i = 0; i < NREG; i++) begin : g_bit
        logic hit_set;
        logic hit_clr;

        // decode whether this register is claimed or released this cycle
        always_comb begin
            hit_set = (set_a_en && set_a_idx == REG_W'(i)) ||
                      (set_b_en && set_b_idx == REG_W'(i));
            hit_clr = (clr_a_en && clr_a_idx == REG_W'(i)) ||
                      (clr_b_en && clr_b_idx == REG_W'(i));
        end

        // hold the busy flag of register i
        always_ff @(posedge clk) begin
            if (!rst_n)       busy[i] <= 1'b0;
            else if (hit_set) busy[i] <= 1'b1;
            else if (hit_clr) busy[i] <= 1'b0;
        end
    end
endmodule

// File: rtl/sb_unit_timer.sv
// Occupancy timer for one non-pipelined functional unit.
// What: on start, counts LAT cycles; the last counted cycle is the
// writeback cycle, in which the unit already accepts a new start.
// Assumes: LAT >= 1; start is only raised while free is high.
module sb_unit_timer #(
    parameter int LAT   = sb_pkg::SB_LAT_ADD,
    parameter int REG_W = sb_pkg::SB_REG_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [REG_W-1:0] start_dst,
    output logic             free,
    output logic             wb_vld,
    output logic [REG_W-1:0] wb_reg
);
    localparam int CNT_W = $clog2(LAT + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(1);

    logic [CNT_W-1:0] cnt;
    logic [REG_W-1:0] dst_q;

    // count down the cycles remaining in the current operation
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (start)      cnt <= CNT_W'(LAT);
        else if (cnt != '0)  cnt <= cnt - LAST;
    end

    // remember the destination of the operation in flight
    always_ff @(posedge clk) begin
        if (!rst_n)     dst_q <= '0;
        else if (start) dst_q <= start_dst;
    end

    // writeback in the final cycle; unit free when idle or finishing
    always_comb begin
        wb_vld = (cnt == LAST);
        wb_reg = dst_q;
        free   = (cnt <= LAST);
    end
endmodule

// File: rtl/sb_issue_sel.sv
// Issue decision for the two oldest pending instructions.
// What: slot 0 goes when its registers are idle and its unit is free;
// slot 1 goes only alongside slot 0, on the other unit, with no
// overlap against slot 0's destination.
// Assumes: busy reflects state at the start of the cycle.
module sb_issue_sel #(
    parameter int REG_W = sb_pkg::SB_REG_W
) (
    input  logic [(1<<REG_W)-1:0] busy,
    input  logic                  add_free,
    input  logic                  mul_free,
    input  logic                  s0_vld,
    input  logic                  s0_mul,
    input  logic [REG_W-1:0]      s0_dst,
    input  logic [REG_W-1:0]      s0_sa,
    input  logic [REG_W-1:0]      s0_sb,
    input  logic                  s1_vld,
    input  logic                  s1_mul,
    input  logic [REG_W-1:0]      s1_dst,
    input  logic [REG_W-1:0]      s1_sa,
    input  logic [REG_W-1:0]      s1_sb,
    output logic                  go0,
    output logic                  go1
);
    logic regs0_idle, regs1_idle;
    logic unit0_ok, unit1_ok;
    logic pair_ok;

    // register hazards against in-flight results (source and destination)
    always_comb begin
        regs0_idle = !busy[s0_sa] && !busy[s0_sb] && !busy[s0_dst];
        regs1_idle = !busy[s1_sa] && !busy[s1_sb] && !busy[s1_dst];
    end

    // structural hazards against the unit each slot needs
    always_comb begin
        unit0_ok = (s0_mul == sb_pkg::UNIT_MUL) ? mul_free : add_free;
        unit1_ok = (s1_mul == sb_pkg::UNIT_MUL) ? mul_free : add_free;
    end

    // pairing rule between the two slots themselves
    always_comb begin
        pair_ok = (s1_mul != s0_mul) &&
                  (s1_sa  != s0_dst) &&
                  (s1_sb  != s0_dst) &&
                  (s1_dst != s0_dst);
    end

    // final in-order grant
    always_comb begin
        go0 = s0_vld && regs0_idle && unit0_ok;
        go1 = go0 && s1_vld && regs1_idle && unit1_ok && pair_ok;
    end
endmodule

// File: rtl/sb_dual_issue.sv
// Top of the in-order dual-issue scoreboard controller.
// What: grants up to one adder and one multiplier issue per cycle from
// the two oldest instructions, tracks register busy state and unit
// occupancy, and reports fixed-latency writebacks.
// Assumes: upstream retires exactly the slots reported as issued and
// shifts the queue before the next cycle.
module sb_dual_issue #(
    parameter int REG_W   = sb_pkg::SB_REG_W,
    parameter int LAT_ADD = sb_pkg::SB_LAT_ADD,
    parameter int LAT_MUL = sb_pkg::SB_LAT_MUL
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             s0_vld,
    input  logic             s0_mul,
    input  logic [REG_W-1:0] s0_dst,
    input  logic [REG_W-1:0] s0_sa,
    input  logic [REG_W-1:0] s0_sb,
    input  logic             s1_vld,
    input  logic             s1_mul,
    input  logic [REG_W-1:0] s1_dst,
    input  logic [REG_W-1:0] s1_sa,
    input  logic [REG_W-1:0] s1_sb,
    output logic             iss0_vld,
    output logic             iss0_unit,
    output logic             iss1_vld,
    output logic             iss1_unit,
    output logic             wb_add_vld,
    output logic [REG_W-1:0] wb_add_reg,
    output logic             wb_mul_vld,
    output logic [REG_W-1:0] wb_mul_reg
);
    localparam int NREG = 1 << REG_W;

    logic [NREG-1:0]  busy;
    logic             add_free, mul_free;
    logic             go0, go1;
    logic             add_start, mul_start;
    logic [REG_W-1:0] add_dst, mul_dst;

    sb_issue_sel #(.REG_W(REG_W)) u_sel (
        .busy     (busy),
        .add_free (add_free),
        .mul_free (mul_free),
        .s0_vld   (s0_vld),
        .s0_mul   (s0_mul),
        .s0_dst   (s0_dst),
        .s0_sa    (s0_sa),
        .s0_sb    (s0_sb),
        .s1_vld   (s1_vld),
        .s1_mul   (s1_mul),
        .s1_dst   (s1_dst),
        .s1_sa    (s1_sa),
        .s1_sb    (s1_sb),
        .go0      (go0),
        .go1      (go1)
    );

    // steer each granted slot to the unit it names
    always_comb begin
        add_start = (go0 && s0_mul == sb_pkg::UNIT_ADD) ||
                    (go1 && s1_mul == sb_pkg::UNIT_ADD);
        mul_start = (go0 && s0_mul == sb_pkg::UNIT_MUL) ||
                    (go1 && s1_mul == sb_pkg::UNIT_MUL);
        add_dst   = (go0 && s0_mul == sb_pkg::UNIT_ADD) ? s0_dst : s1_dst;
        mul_dst   = (go0 && s0_mul == sb_pkg::UNIT_MUL) ? s0_dst : s1_dst;
    end

    sb_unit_timer #(.LAT(LAT_ADD), .REG_W(REG_W)) u_add (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (add_start),
        .start_dst (add_dst),
        .free      (add_free),
        .wb_vld    (wb_add_vld),
        .wb_reg    (wb_add_reg)
    );

    sb_unit_timer #(.LAT(LAT_MUL), .REG_W(REG_W)) u_mul (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (mul_start),
        .start_dst (mul_dst),
        .free      (mul_free),
        .wb_vld    (wb_mul_vld),
        .wb_reg    (wb_mul_reg)
    );

    sb_busy_table #(.REG_W(REG_W)) u_busy (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_a_en  (go0),
        .set_a_idx (s0_dst),
        .set_b_en  (go1),
        .set_b_idx (s1_dst),
        .clr_a_en  (wb_add_vld),
        .clr_a_idx (wb_add_reg),
        .clr_b_en  (wb_mul_vld),
        .clr_b_idx (wb_mul_reg),
        .busy      (busy)
    );

    // issue report towards the queue and the units
    always_comb begin
        iss0_vld  = go0;
        iss0_unit = s0_mul;
        iss1_vld  = go1;
        iss1_unit = s1_mul;
    end
endmodule

// File: rtl/sb_issue_chk.sv
// Property checker for sb_dual_issue, attached by bind.
// What: rebuilds register occupancy and unit ages from the ports only
// and checks ordering, pairing, hazards and writeback timing.
// Assumes: default or small latencies; ages are counted, not delayed.
module sb_issue_chk #(
    parameter int REG_W   = sb_pkg::SB_REG_W,
    parameter int LAT_ADD = sb_pkg::SB_LAT_ADD,
    parameter int LAT_MUL = sb_pkg::SB_LAT_MUL
) (
    input logic             clk,
    input logic             rst_n,
    input logic [REG_W-1:0] s0_dst,
    input logic [REG_W-1:0] s0_sa,
    input logic [REG_W-1:0] s0_sb,
    input logic [REG_W-1:0] s1_dst,
    input logic [REG_W-1:0] s1_sa,
    input logic [REG_W-1:0] s1_sb,
    input logic             iss0_vld,
    input logic             iss0_unit,
    input logic             iss1_vld,
    input logic             iss1_unit,
    input logic             wb_add_vld,
    input logic [REG_W-1:0] wb_add_reg,
    input logic             wb_mul_vld,
    input logic [REG_W-1:0] wb_mul_reg
);
    localparam int NREG = 1 << REG_W;
    localparam int AW_A = $clog2(LAT_ADD + 2);
    localparam int AW_M = $clog2(LAT_MUL + 2);

    logic [NREG-1:0] shadow;
    logic            add_iss, mul_iss;
    logic [AW_A-1:0] add_age;
    logic [AW_M-1:0] mul_age;

    // unit issue events seen at the ports
    always_comb begin
        add_iss = (iss0_vld && iss0_unit == sb_pkg::UNIT_ADD) ||
                  (iss1_vld && iss1_unit == sb_pkg::UNIT_ADD);
        mul_iss = (iss0_vld && iss0_unit == sb_pkg::UNIT_MUL) ||
                  (iss1_vld && iss1_unit == sb_pkg::UNIT_MUL);
    end

    // register occupancy rebuilt from issue and writeback ports
    for (genvar i = 0; i < NREG; i++) begin : g_sh
        always_ff @(posedge clk) begin
            if (!rst_n) shadow[i] <= 1'b0;
            else if ((iss0_vld && s0_dst == REG_W'(i)) ||
                     (iss1_vld && s1_dst == REG_W'(i)))
                shadow[i] <= 1'b1;
            else if ((wb_add_vld && wb_add_reg == REG_W'(i)) ||
                     (wb_mul_vld && wb_mul_reg == REG_W'(i)))
                shadow[i] <= 1'b0;
        end
    end

    // cycles elapsed since the last adder issue, saturating past LAT_ADD
    always_ff @(posedge clk) begin
        if (!rst_n)                               add_age <= '0;
        else if (add_iss)                         add_age <= AW_A'(1);
        else if (add_age != '0 && add_age <= AW_A'(LAT_ADD)) add_age <= add_age + AW_A'(1);
    end

    // cycles elapsed since the last multiplier issue
    always_ff @(posedge clk) begin
        if (!rst_n)                               mul_age <= '0;
        else if (mul_iss)                         mul_age <= AW_M'(1);
        else if (mul_age != '0 && mul_age <= AW_M'(LAT_MUL)) mul_age <= mul_age + AW_M'(1);
    end

    p_in_order_r2: assert property (@(posedge clk) disable iff (!rst_n)
        iss1_vld |-> iss0_vld);

    p_one_per_unit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (iss0_vld && iss1_vld) |-> (iss0_unit != iss1_unit));

    p_no_pair_dep_r5: assert property (@(posedge clk) disable iff (!rst_n)
        iss1_vld |-> (s1_sa != s0_dst && s1_sb != s0_dst && s1_dst != s0_dst));

    p_src_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (iss0_vld |-> (!shadow[s0_sa] && !shadow[s0_sb])) and
        (iss1_vld |-> (!shadow[s1_sa] && !shadow[s1_sb])));

    p_dst_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (iss0_vld |-> !shadow[s0_dst]) and (iss1_vld |-> !shadow[s1_dst]));

    p_add_wb_time_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wb_add_vld |-> (add_age == AW_A'(LAT_ADD)));

    p_add_wb_due_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (add_age == AW_A'(LAT_ADD)) |-> wb_add_vld);

    p_mul_wb_time_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wb_mul_vld |-> (mul_age == AW_M'(LAT_MUL)));

    p_mul_wb_due_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mul_age == AW_M'(LAT_MUL)) |-> wb_mul_vld);
endmodule

bind sb_dual_issue sb_issue_chk #(
    .REG_W(REG_W), .LAT_ADD(LAT_ADD), .LAT_MUL(LAT_MUL)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .s0_dst     (s0_dst),
    .s0_sa      (s0_sa),
    .s0_sb      (s0_sb),
    .s1_dst     (s1_dst),
    .s1_sa      (s1_sa),
    .s1_sb      (s1_sb),
    .iss0_vld   (iss0_vld),
    .iss0_unit  (iss0_unit),
    .iss1_vld   (iss1_vld),
    .iss1_unit  (iss1_unit),
    .wb_add_vld (wb_add_vld),
    .wb_add_reg (wb_add_reg),
    .wb_mul_vld (wb_mul_vld),
    .wb_mul_reg (wb_mul_reg)
);

// File: tb/sim_sb_dual_issue.sv
module sim_sb_dual_issue;
    localparam int RW = 4;
    localparam int NROW = 9;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic s0_vld = 0, s0_mul = 0, s1_vld = 0, s1_mul = 0;
    logic [RW-1:0] s0_dst = 0, s0_sa = 0, s0_sb = 0, s1_dst = 0, s1_sa = 0, s1_sb = 0;
    logic iss0_vld, iss0_unit, iss1_vld, iss1_unit, wb_add_vld, wb_mul_vld;
    logic [RW-1:0] wb_add_reg, wb_mul_reg;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    sb_dual_issue u0 (.*);

    // row layout: {s0 v,m,d,a,b, s1 v,m,d,a,b, expect0, expect1}
    function automatic logic [29:0] row(
        input logic av, input logic am, input int ad, input int aa, input int ab,
        input logic bv, input logic bm, input int bd, input int ba, input int bb,
        input logic e0, input logic e1);
        return {av, am, 4'(ad), 4'(aa), 4'(ab), bv, bm, 4'(bd), 4'(ba), 4'(bb), e0, e1};
    endfunction

    localparam logic [29:0] TBL [NROW] = '{
        row(1,0, 1, 2, 3, 1,1, 4, 5, 6, 1,1),  // R3 add+mul together
        row(1,0, 7, 8, 9, 0,0, 0, 0, 0, 0,0),  // R8 adder still busy
        row(1,0, 7, 8, 9, 1,0,10,11,12, 1,0),  // R4 two adds, R8 free in wb cycle
        row(0,0, 0, 0, 0, 1,1,13, 0, 0, 0,0),  // R2 empty slot 0
        row(1,0,13, 7, 0, 1,1,14, 0, 0, 0,0),  // R6 source busy
        row(1,0,13, 7, 0, 1,1, 4,13, 0, 1,0),  // R10 released, R5 dependent
        row(1,1, 4, 0, 0, 1,0, 5, 0, 0, 1,0),  // R9 mul free, R8 adder busy
        row(1,0, 5, 0, 0, 1,1, 6, 0, 0, 1,0),  // R9 mul busy
        row(1,0, 5, 1, 0, 0,0, 0, 0, 0, 0,0)   // R7 destination busy
    };

    function automatic string tag_of(input int k);
        case (k)
            0: return "R3"; 1: return "R8"; 2: return "R4"; 3: return "R2";
            4: return "R6"; 5: return "R10"; 6: return "R9"; 7: return "R9";
            default: return "R7";
        endcase
    endfunction

    task automatic check(input logic [7:0] act, input logic [7:0] exp, input string req, input string what);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic drive(input logic av, input logic am, input int ad, input int aa, input int ab,
                         input logic bv, input logic bm, input int bd, input int ba, input int bb);
        @(negedge clk);
        s0_vld = av; s0_mul = am; s0_dst = 4'(ad); s0_sa = 4'(aa); s0_sb = 4'(ab);
        s1_vld = bv; s1_mul = bm; s1_dst = 4'(bd); s1_sa = 4'(ba); s1_sb = 4'(bb);
        #2;
    endtask

    task automatic idle();
        drive(0,0,0,0,0, 0,0,0,0,0);
    endtask

    task automatic do_reset();
        idle();
        rst_n = 0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R1: nothing pending after reset
        idle();
        check(8'(wb_add_vld), 0, "R1", "wb_add after reset");
        check(8'(wb_mul_vld), 0, "R1", "wb_mul after reset");
        check(8'(iss0_vld), 0, "R1", "no issue on empty slots");

        // table walk, one row per cycle
        for (int k = 0; k < NROW; k++) begin
            logic [29:0] v;
            v = TBL[k];
            drive(v[29], v[28], int'(v[27:24]), int'(v[23:20]), int'(v[19:16]),
                  v[15], v[14], int'(v[13:10]), int'(v[9:6]), int'(v[5:2]));
            check(8'(iss0_vld), 8'(v[1]), tag_of(k), $sformatf("row %0d slot0", k));
            check(8'(iss1_vld), 8'(v[0]), tag_of(k), $sformatf("row %0d slot1", k));
            if (v[1]) check(8'(iss0_unit), 8'(v[28]), "R11", $sformatf("row %0d unit0", k));
            if (v[0]) check(8'(iss1_unit), 8'(v[14]), "R11", $sformatf("row %0d unit1", k));
        end

        // R7 R9 R10 R8: WAW behind a multiply, then adder timing
        do_reset();
        drive(1,1,3,0,0, 0,0,0,0,0);
        check(8'(iss0_vld), 1, "R9", "mul issues on clean state");
        check(8'(iss0_unit), 1, "R11", "mul unit select");
        for (int c = 1; c <= 5; c++) begin
            drive(1,0,3,0,0, 0,0,0,0,0);
            check(8'(iss0_vld), 0, "R7", $sformatf("add waits on busy dst, cycle %0d", c));
            check(8'(wb_mul_vld), (c == 5) ? 8'd1 : 8'd0, "R9", $sformatf("mul wb at cycle %0d", c));
        end
        check(8'(wb_mul_reg), 3, "R9", "mul wb register");
        drive(1,0,3,0,0, 0,0,0,0,0);
        check(8'(iss0_vld), 1, "R10", "issue cycle after release");
        check(8'(iss0_unit), 0, "R11", "add unit select");
        idle();
        check(8'(wb_add_vld), 0, "R8", "no add wb one cycle after issue");
        drive(1,0,9,0,0, 0,0,0,0,0);
        check(8'(wb_add_vld), 1, "R8", "add wb two cycles after issue");
        check(8'(wb_add_reg), 3, "R8", "add wb register");
        check(8'(iss0_vld), 1, "R8", "adder accepts in wb cycle");

        // R5: slot 1 reads slot 0 destination
        do_reset();
        drive(1,0,2,0,0, 1,1,9,2,0);
        check(8'(iss0_vld), 1, "R5", "slot0 with RAW pair");
        check(8'(iss1_vld), 0, "R5", "slot1 held on RAW pair");
        // R5: slot 1 writes slot 0 destination
        do_reset();
        drive(1,0,2,0,0, 1,1,2,0,0);
        check(8'(iss1_vld), 0, "R5", "slot1 held on WAW pair");
        // R3: WAR between the pair does not block
        do_reset();
        drive(1,0,2,3,0, 1,1,3,0,0);
        check(8'(iss0_vld), 1, "R3", "WAR pair slot0");
        check(8'(iss1_vld), 1, "R3", "WAR pair slot1");

        // R1: reset drops a pending multiply
        do_reset();
        drive(1,1,6,0,0, 0,0,0,0,0);
        check(8'(iss0_vld), 1, "R1", "mul before reset");
        do_reset();
        drive(1,0,6,6,6, 0,0,0,0,0);
        check(8'(iss0_vld), 1, "R1", "register free after reset");
        for (int c = 0; c < 6; c++) begin
            idle();
            check(8'(wb_mul_vld), 0, "R1", $sformatf("no stale mul wb %0d", c));
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule